// File: doc/BRIEF.md
# Eight-bit timer/counter with a shared power-of-two prescaler

This block holds an 8-bit up-counter that software can load at any time and read back continuously. Its count source is either the instruction-cycle strobe (one clock in four) or a chosen edge on an external input pin. A single 8-bit ripple prescaler, with its division ratio picked by a 3-bit code, is given either to the counter or to the watchdog tick path. The two never share it. The side that does not hold the prescaler runs undivided. The prescaler value cannot be read or written.

Every pulse bound for the counter passes through a synchronizer two instruction cycles deep before it can increment the count. A load of the count opens a hold-off window that blocks the next two instruction-cycle increments. A small state machine runs this window. Its states are `HLD_RUN` (counting allowed), `HLD_ONE` and `HLD_TWO`. The transitions are: a load moves any state to `HLD_ONE`; a strobe moves `HLD_ONE` to `HLD_TWO`; a strobe moves `HLD_TWO` to `HLD_RUN`; otherwise the state holds.

When the counter wraps from FFh to 00h it sets a sticky flag. The interrupt request is that flag gated by an enable input. While the sleep input is high the counter stands still.

The 6-bit option word has this layout:
- bit 5 selects the source: 0 is the strobe, 1 is the pin.
- bit 4 selects the pin edge: 0 is rising, 1 is falling.
- bit 3 selects the prescaler owner: 0 is the counter, 1 is the watchdog.
- bits 2:0 hold the ratio code.

Top module: `cnt8_tmr`

## Requirements
- R1: Reset gives these values: count 00h, flag 0, request 0, watchdog tick output 0, and option word 001000b (strobe source, rising edge, prescaler on the watchdog, code 0).
- R2: With option bit 5 = 0 and the prescaler not on the counter, the count rises by one per instruction-cycle strobe. A pulse is counted two strobes after the strobe on which it arrives. Starting from an empty pipeline, the count after N strobes is N-2.
- R3: A count write loads the value on the next clock edge. The next two strobes do not increment. After a write of V followed by N ≥ 2 strobes in undivided strobe mode, the count is V+N-2.
- R4: An increment from FFh gives 00h and sets the flag. The flag stays set until the clear input is pulsed. A wrap in the same cycle as the clear input leaves the flag set.
- R5: The request output is high exactly when the flag and the enable input are both high. Dropping the enable input does not change the flag.
- R6: With option bit 5 = 1, the counter counts pin edges. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges.
- R7: With option bit 3 = 0, ratio code k divides the counter's source by 2^(k+1). A count write in this mode clears the prescaler. After the write, the count advances floor((N-2)/2^(k+1)) times in N strobes.
- R8: With option bit 3 = 1, the watchdog tick output pulses once per 2^k base ticks, one clock after the qualifying base tick. The counter then counts undivided.
- R9: With option bit 3 = 0, every base tick appears on the watchdog tick output one clock later, whatever the ratio code.
- R10: While the sleep input is high, the count does not advance and the flag is not set. The synchronizer is emptied, so after release the first increment comes on the third strobe.
- R11: An option write that changes bit 3 clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cyc_en | input | 1 | Instruction-cycle strobe, one clock wide |
| ext_pin | input | 1 | External count input, asynchronous |
| wdt_base_tick | input | 1 | Watchdog base tick, one clock wide |
| sleep_i | input | 1 | Sleep: stops the counter |
| opt_we | input | 1 | Option word write strobe |
| opt_wd | input | 6 | Option word write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wd | input | 8 | Count write data |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the wrap flag |
| cnt_q | output | 8 | Current count |
| flag_q | output | 1 | Sticky wrap flag |
| irq_o | output | 1 | Interrupt request |
| wdt_tick_o | output | 1 | Post-scaled watchdog tick |

## Verification
The bench targets the exact count after a load. A design that blocks too few strobes would land one or two above V+N-2. A design that skips the synchronizer would land two high.

It checks that a load clears the prescaler and that changing the owner bit clears it too. The owner-bit test runs with the counter asleep, so a design that skips the clear lets a leftover prescaler state emit a watchdog pulse one base tick early.

Edge selection is checked with a pin sequence whose rising and falling edge counts differ. The wrap test checks that the flag stays set under a masked request. The sleep test loads FFh and confirms that no wrap happens until release.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Hold-off window after a count load
    typedef enum logic [1:0] {
        HLD_RUN = 2'd0,
        HLD_ONE = 2'd1,
        HLD_TWO = 2'd2
    } hold_st_t;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
    parameter int PIN_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic pin_i,
    input  logic sleep_i,
    input  logic ext_src,
    input  logic fall_edge,
    output logic src_evt
);

    logic [PIN_STAGES-1:0] pin_sh;
    logic                  rise_det;
    logic                  fall_det;
    logic                  edge_evt;

    // Pin resynchronizer; the two oldest stages feed the edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_sh <= '0;
        end else begin
            pin_sh <= {pin_sh[PIN_STAGES-2:0], pin_i};
        end
    end

    always_comb begin
        rise_det = pin_sh[PIN_STAGES-2] & ~pin_sh[PIN_STAGES-1];
        fall_det = ~pin_sh[PIN_STAGES-2] & pin_sh[PIN_STAGES-1];
        edge_evt = fall_edge ? fall_det : rise_det;
        src_evt  = ~sleep_i & (ext_src ? edge_evt : cyc_en);
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter  int PRE_W = 8,
    localparam int SEL_W = $clog2(PRE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             psa_wdt,
    input  logic [SEL_W-1:0] ratio,
    input  logic             src_evt,
    input  logic             wdt_evt,
    output logic             tmr_pulse,
    output logic             wdt_pulse
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   tap;
    logic [SEL_W:0]   tmr_idx;
    logic             evt;

    // tap[i] is high when the low i prescaler bits are all ones
    assign tap[0] = 1'b1;
    for (genvar i = 0; i < PRE_W; i++) begin : g_tap
        assign tap[i+1] = tap[i] & pre_q[i];
    end

    always_comb begin
        evt       = psa_wdt ? wdt_evt : src_evt;
        tmr_idx   = {1'b0, ratio} + 1'b1;
        tmr_pulse = psa_wdt ? src_evt : (src_evt & tap[tmr_idx]);
        wdt_pulse = psa_wdt ? (wdt_evt & tap[ratio]) : wdt_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (evt) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_sync_hold.sv
module tmr_sync_hold
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic tick,
    input  logic sleep_i,
    input  logic load,
    output logic inc
);

    hold_st_t state_q;
    hold_st_t state_d;
    logic     pend_q;
    logic     stg1_q;
    logic     stg2_q;
    logic     gate_open;

    // Two-strobe synchronizer; pulses between strobes are held in pend_q
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            stg1_q <= 1'b0;
            stg2_q <= 1'b0;
        end else if (sleep_i) begin
            pend_q <= 1'b0;
            stg1_q <= 1'b0;
            stg2_q <= 1'b0;
        end else if (cyc_en) begin
            stg1_q <= pend_q | tick;
            stg2_q <= stg1_q;
            pend_q <= 1'b0;
        end else if (tick) begin
            pend_q <= 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HLD_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = HLD_ONE;
        end else begin
            unique case (state_q)
                HLD_RUN: state_d = HLD_RUN;
                HLD_ONE: if (cyc_en) state_d = HLD_TWO;
                HLD_TWO: if (cyc_en) state_d = HLD_RUN;
                default: state_d = HLD_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            HLD_RUN: gate_open = 1'b1;
            HLD_ONE: gate_open = 1'b0;
            HLD_TWO: gate_open = 1'b0;
            default: gate_open = 1'b0;
        endcase
        inc = cyc_en & stg2_q & gate_open & ~sleep_i & ~load;
    end

endmodule

// File: rtl/cnt8_tmr.sv
module cnt8_tmr #(
    parameter  int CNT_W      = 8,
    parameter  int PRE_W      = 8,
    parameter  int PIN_STAGES = 2,
    localparam int SEL_W      = $clog2(PRE_W),
    localparam int OPT_W      = SEL_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             wdt_base_tick,
    input  logic             sleep_i,
    input  logic             opt_we,
    input  logic [OPT_W-1:0] opt_wd,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wd,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q,
    output logic             irq_o,
    output logic             wdt_tick_o
);

    localparam int B_PSA  = SEL_W;
    localparam int B_EDGE = SEL_W + 1;
    localparam int B_SRC  = SEL_W + 2;
    localparam logic [OPT_W-1:0] OPT_RST = OPT_W'(1) << B_PSA;

    logic [OPT_W-1:0] opt_q;
    logic             src_evt;
    logic             tmr_pulse;
    logic             wdt_pulse;
    logic             pre_clr;
    logic             inc;
    logic             wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q <= OPT_RST;
        end else if (opt_we) begin
            opt_q <= opt_wd;
        end
    end

    assign pre_clr = (cnt_we & ~opt_q[B_PSA])
                   | (opt_we & (opt_wd[B_PSA] != opt_q[B_PSA]));

    tmr_src_sel #(
        .PIN_STAGES(PIN_STAGES)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .pin_i    (ext_pin),
        .sleep_i  (sleep_i),
        .ext_src  (opt_q[B_SRC]),
        .fall_edge(opt_q[B_EDGE]),
        .src_evt  (src_evt)
    );

    tmr_prescaler #(
        .PRE_W(PRE_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pre_clr),
        .psa_wdt  (opt_q[B_PSA]),
        .ratio    (opt_q[SEL_W-1:0]),
        .src_evt  (src_evt),
        .wdt_evt  (wdt_base_tick),
        .tmr_pulse(tmr_pulse),
        .wdt_pulse(wdt_pulse)
    );

    tmr_sync_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en),
        .tick   (tmr_pulse),
        .sleep_i(sleep_i),
        .load   (cnt_we),
        .inc    (inc)
    );

    assign wrap = inc & (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wd;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_tick_o <= 1'b0;
        end else begin
            wdt_tick_o <= wdt_pulse;
        end
    end

    assign irq_o = flag_q & irq_en;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wd,
    input logic [CNT_W-1:0] cnt_q,
    input logic             flag_q,
    input logic             flag_clr,
    input logic             irq_en,
    input logic             irq_o,
    input logic             sleep_i,
    input logic             wdt_base_tick,
    input logic             wdt_tick_o
);

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_we) && cnt_q != $past(cnt_q)) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_q == $past(cnt_wd));

    a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_we) && $past(cnt_q) == '1 && cnt_q == '0) |-> flag_q);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);

    a_r5_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q);

    a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !cnt_we) |=> cnt_q == $past(cnt_q));

    a_r8_wdt_from_base: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick_o |-> $past(wdt_base_tick));

endmodule

bind cnt8_tmr tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_we       (cnt_we),
    .cnt_wd       (cnt_wd),
    .cnt_q        (cnt_q),
    .flag_q       (flag_q),
    .flag_clr     (flag_clr),
    .irq_en       (irq_en),
    .irq_o        (irq_o),
    .sleep_i      (sleep_i),
    .wdt_base_tick(wdt_base_tick),
    .wdt_tick_o   (wdt_tick_o)
);

// File: tb/cnt8_tmr_tb.sv
module cnt8_tmr_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_base_tick = 1'b0;
    logic       sleep_i = 1'b0;
    logic       opt_we = 1'b0;
    logic [5:0] opt_wd = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wd = '0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] cnt_q;
    logic       flag_q;
    logic       irq_o;
    logic       wdt_tick_o;

    int total = 0;
    int bad   = 0;
    int wcnt  = 0;
    logic [1:0] ph = 2'd0;

    cnt8_tmr u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .wdt_base_tick(wdt_base_tick), .sleep_i(sleep_i),
        .opt_we(opt_we), .opt_wd(opt_wd), .cnt_we(cnt_we), .cnt_wd(cnt_wd),
        .irq_en(irq_en), .flag_clr(flag_clr), .cnt_q(cnt_q), .flag_q(flag_q),
        .irq_o(irq_o), .wdt_tick_o(wdt_tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Instruction-cycle strobe: one clock in four
    initial begin
        forever begin
            @(negedge clk);
            ph = ph + 2'd1;
            cyc_en = (ph == 2'd0);
        end
    end

    always @(posedge clk) if (rst_n && wdt_tick_o) wcnt <= wcnt + 1;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wait_ic(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (cyc_en !== 1'b1);
        end
        @(negedge clk);
    endtask

    task automatic align();
        do @(posedge clk); while (cyc_en !== 1'b1);
        @(negedge clk);
    endtask

    task automatic write_cnt(input logic [7:0] v);
        align();
        cnt_we = 1'b1; cnt_wd = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic write_opt(input logic [5:0] v);
        align();
        opt_we = 1'b1; opt_wd = v;
        @(negedge clk);
        opt_we = 1'b0;
    endtask

    task automatic send_base(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) wdt_base_tick = 1'b1;
            @(negedge clk) wdt_base_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pin_level(input logic v);
        ext_pin = v;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", cnt_q, 0);
        chk("R1 flag", flag_q, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 wdt tick", wdt_tick_o, 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_timer();
        wait_ic(5);
        chk("R2 count after 5 strobes", cnt_q, 3);
        wait_ic(4);
        chk("R2 steady rate", cnt_q, 7);
    endtask

    task automatic t_load_hold();
        write_cnt(8'h40);
        wait_ic(1);
        chk("R3 first blocked strobe", cnt_q, 8'h40);
        wait_ic(1);
        chk("R3 second blocked strobe", cnt_q, 8'h40);
        wait_ic(1);
        chk("R3 first increment", cnt_q, 8'h41);
    endtask

    task automatic t_wrap_irq();
        irq_en = 1'b0;
        write_cnt(8'hFE);
        wait_ic(3);
        chk("R4 before wrap", cnt_q, 8'hFF);
        chk("R4 flag before wrap", flag_q, 0);
        wait_ic(1);
        chk("R4 wrap to zero", cnt_q, 8'h00);
        chk("R4 flag set", flag_q, 1);
        chk("R5 request masked", irq_o, 0);
        irq_en = 1'b1;
        #1;
        chk("R5 request enabled", irq_o, 1);
        wait_ic(3);
        chk("R4 flag sticky", flag_q, 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R4 flag cleared", flag_q, 0);
        chk("R5 request drops", irq_o, 0);
        irq_en = 1'b0;
    endtask

    task automatic t_prescale_timer();
        write_opt(6'b000000);
        write_cnt(8'h00);
        wait_ic(20);
        chk("R7 divide by 2", cnt_q, 9);
        write_opt(6'b000010);
        write_cnt(8'h00);
        wait_ic(42);
        chk("R7 divide by 8", cnt_q, 5);
    endtask

    task automatic t_pin_edges();
        write_opt(6'b101000);
        write_cnt(8'h00);
        wait_ic(3);
        for (int i = 0; i < 3; i++) begin
            pin_level(1'b1);
            pin_level(1'b0);
        end
        pin_level(1'b1);
        wait_ic(4);
        chk("R6 rising edges", cnt_q, 4);
        write_opt(6'b111000);
        write_cnt(8'h00);
        wait_ic(3);
        pin_level(1'b0);
        pin_level(1'b1);
        pin_level(1'b0);
        wait_ic(4);
        chk("R6 falling edges", cnt_q, 2);
    endtask

    task automatic t_sleep();
        write_opt(6'b001000);
        sleep_i = 1'b1;
        write_cnt(8'hFF);
        wait_ic(10);
        chk("R10 count frozen", cnt_q, 8'hFF);
        chk("R10 no flag", flag_q, 0);
        sleep_i = 1'b0;
        wait_ic(3);
        chk("R10 wrap after release", cnt_q, 8'h00);
        chk("R10 flag after release", flag_q, 1);
        flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic t_wdt();
        int w0;
        write_opt(6'b000011);
        write_opt(6'b001011);
        w0 = wcnt;
        send_base(24);
        chk("R8 watchdog divide by 8", wcnt - w0, 3);
        write_cnt(8'h10);
        wait_ic(6);
        chk("R8 counter undivided", cnt_q, 8'h14);
        write_opt(6'b001000);
        w0 = wcnt;
        send_base(5);
        chk("R8 watchdog code 0", wcnt - w0, 5);
        write_opt(6'b000111);
        w0 = wcnt;
        send_base(5);
        chk("R9 watchdog undivided", wcnt - w0, 5);
    endtask

    task automatic t_assign_clear();
        int w0;
        write_opt(6'b001001);
        send_base(1);
        sleep_i = 1'b1;
        write_opt(6'b000001);
        write_opt(6'b001001);
        sleep_i = 1'b0;
        w0 = wcnt;
        send_base(1);
        chk("R11 no pulse after one tick", wcnt - w0, 0);
        send_base(1);
        chk("R11 pulse after two ticks", wcnt - w0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_timer();
        t_load_hold();
        t_wrap_irq();
        t_prescale_timer();
        t_pin_edges();
        t_sleep();
        t_wdt();
        t_assign_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule